// File: doc/BRIEF.md
# Multiprocessor UART with Address Filtering

This block is a serial transmitter and receiver for multi-drop links in which one master talks to several nodes on a shared pair of wires. A 16x oversampling tick comes from outside, so every bit lasts sixteen ticks. In the 9-bit multiprocessor mode, every frame carries an extra bit after the data byte. That bit marks the byte as a node address (1) or as payload (0). The transmitter sets this bit from a configuration input. The receiver can compare each incoming address byte with a stored node address and pass on only the traffic sent to this node.

A driver-enable output with programmable polarity frames each transmitted character, so the block can drive a half-duplex RS-485 transceiver directly. The receive side keeps one holding register with a data-available flag, a framing-error flag and an overrun flag. A single interrupt line combines these flags. A mask can block the data-available part of the interrupt so that only errors raise it.

Top module: `mp_uart`

## Requirements
- R1: A transmitted frame is a start bit (0), then the data byte least significant bit first, then a stop bit (1). Each bit lasts 16 ticks, and `txd` rests at 1 while no frame is in progress.
- R2: With `cfg_mp_en`=1, the transmitter inserts one extra bit between the last data bit and the stop bit, and that bit equals `cfg_tx_bit9`.
- R3: `de` is at its active level from the first tick of the start bit to the end of the stop bit. It sits at the opposite level at all other times. The active level is high when `cfg_de_pol`=0 and low when `cfg_de_pol`=1. `tx_busy` is high over the same span.
- R4: The receiver samples each bit at its midpoint, 8 ticks into the bit. A low pulse on `rxd` that returns high before the midpoint of the start bit does not start a frame.
- R5: With `cfg_mp_en`=1 and `cfg_addr_cmp_en`=1, a received frame whose extra bit is 1 is an address. An address equal to `cfg_node_addr` is delivered with `rx_is_addr`=1 and opens the node. Any other address is not delivered and closes the node.
- R6: In the same mode, a frame whose extra bit is 0 is delivered only while the node is open. After reset the node is closed.
- R7: When either `cfg_mp_en` or `cfg_addr_cmp_en` is 0, every received frame is delivered. When `cfg_mp_en`=0, frames carry no extra bit and `rx_is_addr` reads 0.
- R8: A delivered frame whose stop bit samples as 0 sets `err_frame`.
- R9: If a frame is delivered while `rx_avail` is still 1 and `rx_read` is not pulsed in that cycle, `err_overrun` is set and `rx_data` takes the newer byte.
- R10: `irq` is 1 when `err_frame` or `err_overrun` is set, or when `rx_avail` is set and `cfg_err_only_irq`=0. With `cfg_err_only_irq`=1, data alone never raises `irq`.
- R11: A one-cycle `rx_read` pulse clears `rx_avail`, `err_frame` and `err_overrun`, unless a new frame is delivered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| cfg_mp_en | input | 1 | Enable 9-bit frames |
| cfg_tx_bit9 | input | 1 | Value of the transmitted extra bit |
| cfg_de_pol | input | 1 | Driver-enable polarity: 0 active high, 1 active low |
| cfg_addr_cmp_en | input | 1 | Enable address filtering |
| cfg_node_addr | input | 8 | This node's address |
| cfg_err_only_irq | input | 1 | Block the data-available part of the interrupt |
| tx_start | input | 1 | Start a frame with `tx_data` (taken when idle) |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output |
| de | output | 1 | Line driver enable |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Acknowledge the holding register |
| rx_data | output | 8 | Last delivered byte |
| rx_is_addr | output | 1 | Last delivered byte was an address |
| rx_avail | output | 1 | Unread byte held |
| err_frame | output | 1 | Framing error |
| err_overrun | output | 1 | Overrun error |
| irq | output | 1 | Interrupt request |

## Verification
The checker covers, on every cycle, the rules that link separate pieces of logic. A low line must coincide with an active driver enable, and the idle line must be high. A rise of data-available must follow an accepted frame. A mismatched address must leave the holding register untouched. Overrun, framing error and read-clear must follow from the cycle of acceptance, and the error-only mask must hold. The bench scenarios are the only way to show the bit order and timing on the wire, midpoint sampling against a short glitch, and the open/closed state of the node across a series of address and data frames. They also show that a configuration with filtering off delivers every frame.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  // Number of bit slots in one frame: start, data, optional extra bit, stop.
  function automatic int frame_bits(input int dw, input logic mp);
    return dw + 2 + (mp ? 1 : 0);
  endfunction

  // Line driver enable level for a given activity and polarity selection.
  function automatic logic de_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction

  // Decide whether a received frame is handed to the holding register.
  function automatic logic addr_pass(input logic filt_on, input logic is_addr,
                                     input logic hit, input logic open_now);
    if (!filt_on) return 1'b1;
    if (is_addr)  return hit;
    return open_now;
  endfunction

endpackage

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mp_en,
  input  logic              bit9_val,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              txd
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 4);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

  logic [FW-1:0] shreg;
  logic [CW-1:0] tcnt;
  logic [IW-1:0] slots_left;
  logic          bit_end;

  assign bit_end = busy && tick && (tcnt == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      shreg      <= '1;
      tcnt       <= '0;
      slots_left <= '0;
    end else if (!busy) begin
      if (start) begin
        busy       <= 1'b1;
        shreg      <= {1'b1, (mp_en ? bit9_val : 1'b1), data, 1'b0};
        tcnt       <= '0;
        slots_left <= IW'(mpu_pkg::frame_bits(DATA_W, mp_en) - 1);
      end
    end else if (tick) begin
      tcnt <= tcnt + 1'b1;
      if (bit_end) begin
        if (slots_left == '0) begin
          busy <= 1'b0;
        end else begin
          slots_left <= slots_left - 1'b1;
          shreg      <= {1'b1, shreg[FW-1:1]};
        end
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/mpu_rx.sv
module mpu_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mp_en,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              stop_ok
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 4);
  localparam logic [CW-1:0] MID_TICK  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

  logic [1:0]        sync;
  logic              rxs;
  logic              prev;
  logic              run;
  logic [CW-1:0]     tcnt;
  logic [IW-1:0]     slot;
  logic [DATA_W-1:0] shreg;
  logic              b9_raw;
  logic [IW-1:0]     stop_slot;
  logic              mid_sample;
  logic              start_edge;

  assign rxs        = sync[1];
  assign stop_slot  = IW'(mpu_pkg::frame_bits(DATA_W, mp_en) - 1);
  assign mid_sample = run && tick && (tcnt == MID_TICK);
  assign start_edge = !run && tick && prev && !rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      prev    <= 1'b1;
      run     <= 1'b0;
      tcnt    <= '0;
      slot    <= '0;
      shreg   <= '0;
      b9_raw  <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      bit9    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      if (tick) prev <= rxs;
      if (start_edge) begin
        run  <= 1'b1;
        tcnt <= '0;
        slot <= '0;
      end else if (run && tick) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == LAST_TICK) slot <= slot + 1'b1;
        if (mid_sample) begin
          if (slot == '0) begin
            if (rxs) run <= 1'b0;
          end else if (slot <= IW'(DATA_W)) begin
            shreg <= {rxs, shreg[DATA_W-1:1]};
          end else if (slot == stop_slot) begin
            run     <= 1'b0;
            done    <= 1'b1;
            data    <= shreg;
            bit9    <= mp_en ? b9_raw : 1'b0;
            stop_ok <= rxs;
          end else begin
            b9_raw <= rxs;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mpu_filter.sv
module mpu_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] f_data,
  input  logic              f_bit9,
  input  logic              f_stop_ok,
  input  logic              mp_en,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              err_only,
  input  logic              rd,
  output logic              accept,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_addr,
  output logic              avail,
  output logic              ferr,
  output logic              ovr,
  output logic              irq
);
  logic node_open;
  logic filt_on;
  logic addr_hit;

  assign filt_on  = mp_en && cmp_en;
  assign addr_hit = (f_data == node_addr);
  assign accept   = done && mpu_pkg::addr_pass(filt_on, f_bit9, addr_hit, node_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_open  <= 1'b0;
      rx_data    <= '0;
      rx_is_addr <= 1'b0;
      avail      <= 1'b0;
      ferr       <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      if (done && filt_on && f_bit9) node_open <= addr_hit;
      if (accept) begin
        rx_data    <= f_data;
        rx_is_addr <= f_bit9;
        avail      <= 1'b1;
        ferr       <= !f_stop_ok;
        if (avail && !rd) ovr <= 1'b1;
        else if (rd)      ovr <= 1'b0;
      end else if (rd) begin
        avail <= 1'b0;
        ferr  <= 1'b0;
        ovr   <= 1'b0;
      end
    end
  end

  assign irq = (avail && !err_only) || ferr || ovr;

endmodule

// File: rtl/mp_uart.sv
module mp_uart #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              cfg_mp_en,
  input  logic              cfg_tx_bit9,
  input  logic              cfg_de_pol,
  input  logic              cfg_addr_cmp_en,
  input  logic [DATA_W-1:0] cfg_node_addr,
  input  logic              cfg_err_only_irq,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              txd,
  output logic              de,
  input  logic              rxd,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_addr,
  output logic              rx_avail,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq
);
  logic              frame_done;
  logic [DATA_W-1:0] f_data;
  logic              f_bit9;
  logic              f_stop_ok;
  logic              accept;

  mpu_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .mp_en(cfg_mp_en),
    .bit9_val(cfg_tx_bit9), .start(tx_start), .data(tx_data),
    .busy(tx_busy), .txd(txd)
  );

  assign de = mpu_pkg::de_level(tx_busy, cfg_de_pol);

  mpu_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .mp_en(cfg_mp_en), .rxd(rxd),
    .done(frame_done), .data(f_data), .bit9(f_bit9), .stop_ok(f_stop_ok)
  );

  mpu_filter #(.DATA_W(DATA_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .f_data(f_data),
    .f_bit9(f_bit9), .f_stop_ok(f_stop_ok), .mp_en(cfg_mp_en),
    .cmp_en(cfg_addr_cmp_en), .node_addr(cfg_node_addr),
    .err_only(cfg_err_only_irq), .rd(rx_read), .accept(accept),
    .rx_data(rx_data), .rx_is_addr(rx_is_addr), .avail(rx_avail),
    .ferr(err_frame), .ovr(err_overrun), .irq(irq)
  );

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mp_en,
  input logic              cfg_addr_cmp_en,
  input logic [DATA_W-1:0] cfg_node_addr,
  input logic              cfg_de_pol,
  input logic              cfg_err_only_irq,
  input logic              tx_busy,
  input logic              txd,
  input logic              de,
  input logic              rx_read,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_avail,
  input logic              err_frame,
  input logic              err_overrun,
  input logic              irq,
  input logic              frame_done,
  input logic [DATA_W-1:0] f_data,
  input logic              f_bit9,
  input logic              f_stop_ok,
  input logic              accept
);
  AST_LOW_LINE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> (de != cfg_de_pol)); // R3
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R1
  AST_AVAIL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> $past(accept)); // R6
  AST_MISMATCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cfg_mp_en && cfg_addr_cmp_en && f_bit9 && (f_data != cfg_node_addr))
      |=> $stable(rx_data)); // R5
  AST_ERR_ONLY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_only_irq && !err_frame && !err_overrun) |-> !irq); // R10
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rx_avail && !rx_read) |=> err_overrun); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !accept) |=> (!rx_avail && !err_frame && !err_overrun)); // R11
  AST_FRAME_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !f_stop_ok) |=> err_frame); // R8
endmodule

bind mp_uart mpu_checker #(.DATA_W(DATA_W)) u_mpu_checker (
  .clk(clk), .rst_n(rst_n), .cfg_mp_en(cfg_mp_en),
  .cfg_addr_cmp_en(cfg_addr_cmp_en), .cfg_node_addr(cfg_node_addr),
  .cfg_de_pol(cfg_de_pol), .cfg_err_only_irq(cfg_err_only_irq),
  .tx_busy(tx_busy), .txd(txd), .de(de), .rx_read(rx_read),
  .rx_data(rx_data), .rx_avail(rx_avail), .err_frame(err_frame),
  .err_overrun(err_overrun), .irq(irq), .frame_done(frame_done),
  .f_data(f_data), .f_bit9(f_bit9), .f_stop_ok(f_stop_ok), .accept(accept)
);

// File: tb/tb_mp_uart.sv
module tb_mp_uart;
  localparam int CLK_P = 10;
  localparam int BIT_T = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       cfg_mp_en = 1'b0, cfg_tx_bit9 = 1'b0, cfg_de_pol = 1'b0;
  logic       cfg_addr_cmp_en = 1'b0, cfg_err_only_irq = 1'b0;
  logic [7:0] cfg_node_addr = 8'h5A;
  logic       tx_start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rxd = 1'b1, rx_read = 1'b0;
  logic       tx_busy, txd, de, rx_is_addr, rx_avail, err_frame, err_overrun, irq;
  logic [7:0] rx_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mp_uart dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_mp_en(cfg_mp_en),
    .cfg_tx_bit9(cfg_tx_bit9), .cfg_de_pol(cfg_de_pol),
    .cfg_addr_cmp_en(cfg_addr_cmp_en), .cfg_node_addr(cfg_node_addr),
    .cfg_err_only_irq(cfg_err_only_irq), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .txd(txd), .de(de), .rxd(rxd), .rx_read(rx_read),
    .rx_data(rx_data), .rx_is_addr(rx_is_addr), .rx_avail(rx_avail),
    .err_frame(err_frame), .err_overrun(err_overrun), .irq(irq)
  );

  // Vector fields: {mp, cmp, bit9, expect_delivered, data[7:0]}; node address 0x5A.
  localparam logic [11:0] VEC [9] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h11},  // data while closed: dropped
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h33},  // foreign address: dropped
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h5A},  // own address: delivered
    {1'b1, 1'b1, 1'b0, 1'b1, 8'hC4},  // data while open
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h01},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h77},  // foreign address closes node
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h99},  // data while closed again
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h42},  // filtering off
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hE7}   // 8-bit frames
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input logic b9, input logic mp, input logic stp);
    @(negedge clk); rxd = 1'b0; repeat (BIT_T - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rxd = d[i]; repeat (BIT_T - 1) @(negedge clk);
    end
    if (mp) begin
      @(negedge clk); rxd = b9; repeat (BIT_T - 1) @(negedge clk);
    end
    @(negedge clk); rxd = stp; repeat (BIT_T - 1) @(negedge clk);
    @(negedge clk); rxd = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [10:0] exp_bits;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1 reset txd", txd, 1);
    chk("R3 reset de", de, 0);
    chk("R11 reset avail", rx_avail, 0);
    chk("R10 reset irq", irq, 0);

    // Transmit 0xA5 with extra bit 1, active-low DE
    cfg_mp_en = 1'b1; cfg_tx_bit9 = 1'b1; cfg_de_pol = 1'b1;
    @(negedge clk);
    chk("R3 idle de active-low", de, 1);
    tx_data = 8'hA5; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    exp_bits = {1'b1, 1'b1, 8'hA5, 1'b0};
    repeat (8) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      if (k > 0) repeat (BIT_T) @(negedge clk);
      chk(k == 9 ? "R2 extra bit" : "R1 tx bit", txd, exp_bits[k]);
      chk("R3 de during frame", de, 0);
    end
    repeat (8) @(negedge clk);
    chk("R3 busy done", tx_busy, 0);
    chk("R3 de after frame", de, 1);
    cfg_de_pol = 1'b0;

    // Short glitch must not start a frame
    cfg_mp_en = 1'b0; cfg_addr_cmp_en = 1'b0;
    @(negedge clk); rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT_T) @(negedge clk);
    chk("R4 glitch ignored", rx_avail, 0);

    // Table walk over filtering cases
    for (int v = 0; v < 9; v++) begin
      cfg_mp_en = VEC[v][11]; cfg_addr_cmp_en = VEC[v][10];
      send_rx(VEC[v][7:0], VEC[v][9], VEC[v][11], 1'b1);
      chk("R5 R6 R7 delivered", rx_avail, VEC[v][8]);
      chk("R10 irq follows data", irq, VEC[v][8]);
      if (VEC[v][8]) begin
        chk("R5 R6 R7 data", rx_data, VEC[v][7:0]);
        chk("R5 R7 addr flag", rx_is_addr, VEC[v][9]);
        do_read();
        chk("R11 read clears", rx_avail, 0);
      end
    end

    // Error-only interrupt mask
    cfg_mp_en = 1'b0; cfg_addr_cmp_en = 1'b0; cfg_err_only_irq = 1'b1;
    send_rx(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R10 masked data irq", irq, 0);
    chk("R10 masked data avail", rx_avail, 1);
    do_read();

    // Framing error
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    chk("R8 framing error", err_frame, 1);
    chk("R10 error irq", irq, 1);
    do_read();
    chk("R11 error cleared", err_frame, 0);

    // Overrun
    send_rx(8'h10, 1'b0, 1'b0, 1'b1);
    send_rx(8'h20, 1'b0, 1'b0, 1'b1);
    chk("R9 overrun flag", err_overrun, 1);
    chk("R9 newest data", rx_data, 8'h20);
    chk("R10 overrun irq", irq, 1);
    do_read();
    chk("R11 overrun cleared", err_overrun, 0);
    chk("R11 avail cleared", rx_avail, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule